// File: doc/BRIEF.md
# Shared Memory Bank Conflict Serializer

This block takes one warp-wide read request for a banked on-chip scratch memory and splits it into the smallest number of passes that the banks can serve. The request has 32 lanes, and each lane carries a byte address and an active bit. The memory has 32 banks, interleaved one 32-bit word per bank. In every pass, each bank can deliver one word. Any number of lanes that want that same word are served together by broadcast.

Once a request is accepted, the block emits one pass per cycle. Each pass carries an enable and a word address for every bank, plus the mask of lanes that the pass serves. The surrounding pipeline reads the bank arrays with the per-bank word addresses and steers the returned data to the lanes in the mask. After the last pass, the block raises `done` for one cycle and shows the total pass count. Only then does it accept the next request. The bank storage itself sits outside the block.

Top module: `sbc_serializer`

## Requirements
- R1: A lane's bank is bits [6:2] of its byte address, which is (address / 4) mod 32. Its word address is the address shifted right by 2. The two lowest address bits have no effect on bank, word or pass count.
- R2: Lanes that request the same word address are always served in the same pass, with a single bank access (broadcast).
- R3: A request whose active lanes all fall in distinct banks completes in exactly one pass.
- R4: The pass count equals the largest number of distinct word addresses that active lanes request from any single bank. A word stride of 32 gives 32 passes and a word stride of 33 gives one pass.
- R5: In each pass, every bank that still has unserved lanes is enabled. It drives the word wanted by its lowest-numbered unserved lane. The lane mask holds exactly the unserved lanes that want one of the driven words.
- R6: Every active lane appears in exactly one pass mask during a request, and no lane is served twice.
- R7: Inactive lanes are never served and add no passes. A request with no active lanes emits no pass and raises `done` with a count of zero on the cycle after acceptance.
- R8: `req_ready` is high only while idle, and a request is taken when `req_valid` and `req_ready` are both high at a clock edge. Passes appear on consecutive cycles starting one cycle after acceptance. `done` is a one-cycle pulse on the cycle after the last pass, and `req_ready` returns on the cycle after `done`. Requests offered while busy are not taken.
- R9: After synchronous reset the block is idle: `req_ready` is 1, while `pass_valid`, `done`, all bank enables, the lane mask and `pass_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_active | input | 32 | Per-lane active bits |
| req_addr | input | 32x32 | Per-lane byte addresses, lane 0 in the lowest slice |
| pass_valid | output | 1 | A pass is being emitted this cycle |
| pass_lane_mask | output | 32 | Lanes served by this pass |
| pass_bank_en | output | 32 | Banks accessed in this pass |
| pass_bank_word | output | 32x30 | Word address driven to each bank |
| done | output | 1 | One-cycle pulse when all active lanes are served |
| pass_count | output | 6 | Number of passes of the last request, valid with done |

## Verification
The bench builds the block with its default sizes: 32 lanes, 32 banks and 32-bit addresses. This puts the real worst case in reach, a 32-way conflict that needs 32 passes, as well as the stride-33 pattern that spreads across all banks. With the full lane count, the count register is checked at its largest value of 32, and a request can combine broadcasts with multi-word conflicts inside one bank. Pseudo-random patterns limited to a small word range force many bank collisions, and every pass is compared against a lowest-lane-first model.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Default geometry of the serializer
    localparam int unsigned SBC_LANES      = 32;
    localparam int unsigned SBC_BANKS      = 32;
    localparam int unsigned SBC_ADDR_W     = 32;
    localparam int unsigned SBC_WORD_BYTES = 4;

    // Control phases
    typedef enum logic [1:0] {
        SBC_IDLE   = 2'd0,
        SBC_BUSY   = 2'd1,
        SBC_FINISH = 2'd2
    } sbc_phase_e;

    // Width needed to hold the value n, never below one bit
    function automatic int unsigned sbc_width_of(input int unsigned n);
        int unsigned w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/sbc_bank_pick.sv
// Selects, for one bank, the word wanted by the lowest-numbered pending lane.
module sbc_bank_pick #(
    parameter int unsigned LANES   = 32,
    parameter int unsigned BANKS   = 32,
    parameter int unsigned WORD_AW = 30,
    parameter int unsigned BANK_ID = 0
) (
    input  logic [LANES-1:0]              pending,
    input  logic [LANES-1:0][WORD_AW-1:0] words,
    output logic                          bank_en,
    output logic [WORD_AW-1:0]            bank_word
);
    localparam int unsigned BANK_W = $clog2(BANKS);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

    always_comb begin
        bank_en   = 1'b0;
        bank_word = '0;
        // Descending scan: the last hit written is the lowest lane index
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i] && (words[i][BANK_W-1:0] == MY_BANK)) begin
                bank_en   = 1'b1;
                bank_word = words[i];
            end
        end
    end

endmodule

// File: rtl/sbc_lane_match.sv
// Marks each pending lane whose bank is driving exactly the word it wants.
module sbc_lane_match #(
    parameter int unsigned LANES   = 32,
    parameter int unsigned BANKS   = 32,
    parameter int unsigned WORD_AW = 30
) (
    input  logic [LANES-1:0]              pending,
    input  logic [LANES-1:0][WORD_AW-1:0] words,
    input  logic [BANKS-1:0]              bank_en,
    input  logic [BANKS-1:0][WORD_AW-1:0] bank_word,
    output logic [LANES-1:0]              served
);
    localparam int unsigned BANK_W = $clog2(BANKS);

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            logic [BANK_W-1:0] b;
            b = words[k][BANK_W-1:0];
            served[k] = pending[k] && bank_en[b] && (bank_word[b] == words[k]);
        end
    end

endmodule

// File: rtl/sbc_ctrl.sv
// Request capture, pending-lane bookkeeping, pass counting and phase control.
module sbc_ctrl
    import sbc_pkg::*;
#(
    parameter int unsigned LANES   = 32,
    parameter int unsigned WORD_AW = 30,
    parameter int unsigned CNT_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [LANES-1:0]              req_active,
    input  logic [LANES-1:0][WORD_AW-1:0] req_words,
    input  logic [LANES-1:0]              served,
    output logic                          req_ready,
    output logic                          pass_valid,
    output logic                          done,
    output logic [LANES-1:0]              pending_q,
    output logic [LANES-1:0][WORD_AW-1:0] words_q,
    output logic [CNT_W-1:0]              count_q
);
    sbc_phase_e       phase_q;
    logic [LANES-1:0] pending_next;

    assign pending_next = pending_q & ~served;
    assign req_ready    = (phase_q == SBC_IDLE);
    assign pass_valid   = (phase_q == SBC_BUSY);
    assign done         = (phase_q == SBC_FINISH);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= SBC_IDLE;
            pending_q <= '0;
            words_q   <= '0;
            count_q   <= '0;
        end else begin
            unique case (phase_q)
                SBC_IDLE: begin
                    if (req_valid) begin
                        words_q   <= req_words;
                        pending_q <= req_active;
                        count_q   <= '0;
                        phase_q   <= (|req_active) ? SBC_BUSY : SBC_FINISH;
                    end
                end
                SBC_BUSY: begin
                    pending_q <= pending_next;
                    count_q   <= count_q + CNT_W'(1);
                    if (pending_next == '0) begin
                        phase_q <= SBC_FINISH;
                    end
                end
                SBC_FINISH: begin
                    phase_q <= SBC_IDLE;
                end
                default: begin
                    phase_q <= SBC_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sbc_serializer.sv
// Splits a warp-wide scratch-memory read into conflict-free bank passes.
module sbc_serializer
    import sbc_pkg::*;
#(
    parameter int unsigned LANES      = SBC_LANES,
    parameter int unsigned BANKS      = SBC_BANKS,
    parameter int unsigned ADDR_W     = SBC_ADDR_W,
    parameter int unsigned WORD_BYTES = SBC_WORD_BYTES,
    localparam int unsigned OFF_W     = $clog2(WORD_BYTES),
    localparam int unsigned WORD_AW   = ADDR_W - OFF_W,
    localparam int unsigned CNT_W     = sbc_width_of(LANES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [LANES-1:0]              req_active,
    input  logic [LANES-1:0][ADDR_W-1:0]  req_addr,
    output logic                          pass_valid,
    output logic [LANES-1:0]              pass_lane_mask,
    output logic [BANKS-1:0]              pass_bank_en,
    output logic [BANKS-1:0][WORD_AW-1:0] pass_bank_word,
    output logic                          done,
    output logic [CNT_W-1:0]              pass_count
);
    logic [LANES-1:0][WORD_AW-1:0] req_words;
    logic [LANES-1:0][OFF_W-1:0]   req_offsets;
    logic                          offsets_unused;
    logic [LANES-1:0][WORD_AW-1:0] words_q;
    logic [LANES-1:0]              pending_q;
    logic [BANKS-1:0]              bank_en;
    logic [BANKS-1:0][WORD_AW-1:0] bank_word;
    logic [LANES-1:0]              served;

    // Byte addresses become word addresses; sub-word offset bits are dropped
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            req_words[i]   = req_addr[i][ADDR_W-1:OFF_W];
            req_offsets[i] = req_addr[i][OFF_W-1:0];
        end
    end
    assign offsets_unused = ^req_offsets;

    sbc_ctrl #(
        .LANES  (LANES),
        .WORD_AW(WORD_AW),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_active(req_active),
        .req_words (req_words),
        .served    (served),
        .req_ready (req_ready),
        .pass_valid(pass_valid),
        .done      (done),
        .pending_q (pending_q),
        .words_q   (words_q),
        .count_q   (pass_count)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sbc_bank_pick #(
            .LANES  (LANES),
            .BANKS  (BANKS),
            .WORD_AW(WORD_AW),
            .BANK_ID(b)
        ) u_pick (
            .pending  (pending_q),
            .words    (words_q),
            .bank_en  (bank_en[b]),
            .bank_word(bank_word[b])
        );
    end

    sbc_lane_match #(
        .LANES  (LANES),
        .BANKS  (BANKS),
        .WORD_AW(WORD_AW)
    ) u_match (
        .pending  (pending_q),
        .words    (words_q),
        .bank_en  (bank_en),
        .bank_word(bank_word),
        .served   (served)
    );

    assign pass_lane_mask = served  & {LANES{pass_valid}};
    assign pass_bank_en   = bank_en & {BANKS{pass_valid}};
    assign pass_bank_word = bank_word;

endmodule

// File: rtl/sbc_serializer_chk.sv
// Protocol and coverage properties of the serializer, attached by bind.
module sbc_serializer_chk #(
    parameter int unsigned LANES = 32,
    parameter int unsigned BANKS = 32,
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LANES-1:0] req_active,
    input logic             pass_valid,
    input logic [LANES-1:0] pass_lane_mask,
    input logic [BANKS-1:0] pass_bank_en,
    input logic             done,
    input logic [CNT_W-1:0] pass_count
);
    logic [LANES-1:0] active_q;
    logic [LANES-1:0] served_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= '0;
            served_acc <= '0;
        end else if (req_valid && req_ready) begin
            active_q   <= req_active;
            served_acc <= '0;
        end else if (pass_valid) begin
            served_acc <= served_acc | pass_lane_mask;
        end
    end

    // R8
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({req_ready, pass_valid, done}));

    // R6
    no_double_serve_chk: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> ((pass_lane_mask & served_acc) == '0));

    // R7
    inactive_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> ((pass_lane_mask & ~active_q) == '0));

    // R6
    all_served_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (served_acc == active_q));

    // R5
    pass_progress_chk: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> (pass_lane_mask != '0 && pass_bank_en != '0));

    // R2
    broadcast_share_chk: assert property (@(posedge clk) disable iff (rst)
        pass_valid |-> ($countones(pass_bank_en) <= $countones(pass_lane_mask)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass_count <= CNT_W'(LANES)));

    // R9
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pass_valid |-> (pass_lane_mask == '0 && pass_bank_en == '0));

endmodule

bind sbc_serializer sbc_serializer_chk #(
    .LANES(LANES),
    .BANKS(BANKS),
    .CNT_W(CNT_W)
) u_sbc_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_active    (req_active),
    .pass_valid    (pass_valid),
    .pass_lane_mask(pass_lane_mask),
    .pass_bank_en  (pass_bank_en),
    .done          (done),
    .pass_count    (pass_count)
);

// File: tb/sbc_serializer_test.sv
module sbc_serializer_test;
    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int AW    = 32;
    localparam int WAW   = 30;
    localparam int CW    = 6;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      req_valid = 1'b0;
    logic                      req_ready;
    logic [LANES-1:0]          req_active = '0;
    logic [LANES-1:0][AW-1:0]  req_addr = '0;
    logic                      pass_valid;
    logic [LANES-1:0]          pass_lane_mask;
    logic [BANKS-1:0]          pass_bank_en;
    logic [BANKS-1:0][WAW-1:0] pass_bank_word;
    logic                      done;
    logic [CW-1:0]             pass_count;

    int checks = 0;
    int errors = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk; // 50 MHz

    sbc_serializer uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr), .pass_valid(pass_valid),
        .pass_lane_mask(pass_lane_mask), .pass_bank_en(pass_bank_en),
        .pass_bank_word(pass_bank_word), .done(done), .pass_count(pass_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bank data model: content of each word is a fixed hash of its address
    function automatic logic [31:0] bank_data(input logic [WAW-1:0] w);
        return {2'b0, w} * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [WAW-1:0] word_of(input logic [AW-1:0] a);
        return a[AW-1:2];
    endfunction

    function automatic int bank_of(input logic [AW-1:0] a);
        return int'(a[6:2]);
    endfunction

    // Expected pass count: max distinct words in any bank
    function automatic int max_distinct(input logic [LANES-1:0][AW-1:0] a,
                                        input logic [LANES-1:0] act);
        int per_bank [BANKS];
        int best = 0;
        foreach (per_bank[b]) per_bank[b] = 0;
        for (int i = 0; i < LANES; i++) begin
            bit dup = 0;
            if (!act[i]) continue;
            for (int j = 0; j < i; j++)
                if (act[j] && word_of(a[j]) == word_of(a[i])) dup = 1;
            if (!dup) per_bank[bank_of(a[i])]++;
        end
        foreach (per_bank[b]) if (per_bank[b] > best) best = per_bank[b];
        return best;
    endfunction

    // Lanes expected in the next pass: lowest pending lane of each bank picks the word
    function automatic logic [LANES-1:0] model_mask(input logic [LANES-1:0][AW-1:0] a,
                                                     input logic [LANES-1:0] pend);
        logic [LANES-1:0] m = '0;
        for (int k = 0; k < LANES; k++) begin
            if (!pend[k]) continue;
            for (int j = 0; j <= k; j++) begin
                if (pend[j] && bank_of(a[j]) == bank_of(a[k])) begin
                    m[k] = (word_of(a[j]) == word_of(a[k]));
                    break;
                end
            end
        end
        return m;
    endfunction

    task automatic run_req(input string req, input logic [LANES-1:0][AW-1:0] a,
                           input logic [LANES-1:0] act);
        int exp_n = max_distinct(a, act);
        int passes = 0;
        logic [LANES-1:0] pend = act;
        check(req_ready == 1'b1, "R8", "ready before request", req_ready, 1);
        req_addr   = a;
        req_active = act;
        req_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 2 * LANES + 4; cyc++) begin
            if (pass_valid) begin
                logic [LANES-1:0] m = model_mask(a, pend);
                bit data_ok = 1;
                check(pass_lane_mask == m, "R5", "pass lane mask", pass_lane_mask, m);
                for (int k = 0; k < LANES; k++) begin
                    if (m[k]) begin
                        int b = bank_of(a[k]);
                        if (!pass_bank_en[b] ||
                            bank_data(pass_bank_word[b]) != bank_data(word_of(a[k])))
                            data_ok = 0;
                    end
                end
                check(data_ok, "R1", "bank word feeds served lanes", data_ok, 1);
                check(req_ready == 1'b0, "R8", "ready low while busy", req_ready, 0);
                pend &= ~m;
                passes++;
            end else if (done) begin
                check(pass_count == exp_n, req, "pass count", pass_count, exp_n);
                check(passes == exp_n, req, "passes emitted", passes, exp_n);
                check(pend == '0, "R6", "lanes left unserved", $countones(pend), 0);
                @(negedge clk);
                check(req_ready && !done, "R8", "idle after done", req_ready, 1);
                return;
            end else begin
                check(0, "R8", "gap between passes", cyc, passes);
                return;
            end
            @(negedge clk);
        end
        check(0, req, "request never finished", passes, exp_n);
    endtask

    task automatic t_reset();
        check(req_ready == 1 && !pass_valid && !done, "R9", "idle after reset", req_ready, 1);
        check(pass_count == 0 && pass_lane_mask == 0 && pass_bank_en == 0, "R9",
              "outputs clear after reset", pass_count, 0);
    endtask

    task automatic t_unit_stride();
        logic [LANES-1:0][AW-1:0] a;
        for (int i = 0; i < LANES; i++) a[i] = 32'h2000 + i * 4;
        run_req("R3", a, '1);
    endtask

    task automatic t_stride32();
        logic [LANES-1:0][AW-1:0] a;
        for (int i = 0; i < LANES; i++) a[i] = i * 128;
        run_req("R4", a, '1);
        check(pass_count == 32, "R4", "stride 32 worst case", pass_count, 32);
    endtask

    task automatic t_stride33();
        logic [LANES-1:0][AW-1:0] a;
        for (int i = 0; i < LANES; i++) a[i] = i * 132;
        run_req("R4", a, '1);
        check(pass_count == 1, "R4", "stride 33 single pass", pass_count, 1);
    endtask

    task automatic t_broadcast();
        logic [LANES-1:0][AW-1:0] a;
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_0440;
        run_req("R2", a, '1);
        check(pass_count == 1, "R2", "broadcast one pass", pass_count, 1);
    endtask

    task automatic t_low_bits();
        logic [LANES-1:0][AW-1:0] a;
        for (int i = 0; i < LANES; i++) a[i] = i * 4 + (i % 4);
        run_req("R1", a, '1);
        check(pass_count == 1, "R1", "offset bits ignored", pass_count, 1);
    endtask

    task automatic t_mixed();
        logic [LANES-1:0][AW-1:0] a;
        for (int i = 0; i < LANES; i++) a[i] = (((i / 4) % 4) * 32 + (i % 4)) * 4;
        run_req("R2", a, '1);
        check(pass_count == 4, "R4", "broadcast plus 4-way conflict", pass_count, 4);
    endtask

    task automatic t_inactive();
        logic [LANES-1:0][AW-1:0] a;
        logic [LANES-1:0] act = '0;
        for (int i = 0; i < LANES; i++) a[i] = i * 128;
        act[5] = 1; act[9] = 1; act[20] = 1;
        run_req("R7", a, act);
        check(pass_count == 3, "R7", "only active lanes counted", pass_count, 3);
    endtask

    task automatic t_empty();
        logic [LANES-1:0][AW-1:0] a;
        for (int i = 0; i < LANES; i++) a[i] = i * 128;
        run_req("R7", a, '0);
        check(pass_count == 0, "R7", "empty request count", pass_count, 0);
    endtask

    task automatic t_random(input int rounds);
        for (int r = 0; r < rounds; r++) begin
            logic [LANES-1:0][AW-1:0] a;
            logic [LANES-1:0] act;
            for (int i = 0; i < LANES; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                a[i] = ((lfsr[15:0] % 96) * 4) + lfsr[17:16];
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            act = lfsr | 32'h0000_0101;
            run_req("R4", a, act);
        end
    endtask

    task automatic t_handshake();
        logic [LANES-1:0][AW-1:0] a;
        logic [LANES-1:0] act = 32'h0000_000F;
        int passes = 0;
        for (int i = 0; i < LANES; i++) a[i] = i * 128;
        req_addr = a; req_active = act; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // Offer a second request while busy; it must wait
        for (int i = 0; i < LANES; i++) req_addr[i] = 32'h0000_0880;
        req_active = '1;
        while (pass_valid && passes < 40) begin
            check(!req_ready, "R8", "not ready during passes", req_ready, 0);
            passes++;
            @(negedge clk);
        end
        check(done && pass_count == 4, "R8", "first request kept", pass_count, 4);
        @(negedge clk);
        check(req_ready, "R8", "ready after done", req_ready, 1);
        @(negedge clk);
        check(pass_valid && pass_lane_mask == '1, "R8", "held request taken",
              pass_lane_mask, 32'hFFFF_FFFF);
        req_valid = 1'b0;
        @(negedge clk);
        check(done && pass_count == 1, "R8", "second request count", pass_count, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unit_stride();
        t_stride32();
        t_stride33();
        t_broadcast();
        t_low_bits();
        t_mixed();
        t_inactive();
        t_empty();
        t_random(20);
        t_handshake();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule